// File: doc/BRIEF.md
# Microcontroller Program Sequencer

This block is the instruction-flow unit of a small 8-bit microcontroller that executes one instruction per clock. It owns the program counter, drives the address port of a synchronous instruction ROM and receives the instruction word one clock later. Each word it receives is either handed to the datapath with an execute strobe, or marked as dead. A word is dead in the first cycle after reset and in the slot that follows any taken branch.

The sequencer decodes subroutine calls and returns on its own. A call is unconditional, or it depends on the zero or carry flag that the datapath supplies. A taken call saves the address that follows the call on a small internal hardware stack. A return takes that address back from the stack. Because the ROM answers one cycle late, the fall-through word is already fetched when a branch is resolved. The sequencer therefore blanks that word, so a taken call or return costs two cycles and every other instruction costs one.

Top module: `mcu_flow_unit`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `rom_addr` is 0 and `exec_en` is 0. In the next cycle, the word stored at address 0 is executed.
- R2: When an executed word is neither a taken call nor a return, `rom_addr` rises by 1 in the next cycle, wrapping modulo 2^PC_W, and the following word is executed with no gap.
- R3: `instr_out` equals `rom_data` whenever `exec_en` is 1, and it is all zeros whenever `exec_en` is 0.
- R4: An executed word whose top 8 bits are 11000000 is an unconditional call to the address in its low PC_W bits. In the next cycle `rom_addr` equals that target and `exec_en` is 0. One cycle later, the word at the target is executed.
- R5: A top byte of 110001cc is a conditional call. The call is taken when cc=00 and zero is set, when cc=01 and zero is clear, when cc=10 and carry is set, or when cc=11 and carry is clear. The flags are sampled in the cycle the call is executed. A taken conditional call behaves as in R4.
- R6: A conditional call whose condition is false behaves as a plain instruction (R2) and leaves the stack unchanged.
- R7: A taken call saves its own address plus 1. An executed word whose top byte is 10101100 is a return. It takes the most recently saved address and loads it into `rom_addr` in the next cycle, with a one-cycle dead slot.
- R8: Saved addresses come back in last-in, first-out order across up to STK_DEPTH nested calls.
- R9: A taken call made while STK_DEPTH addresses are already saved still branches. Its return address is discarded, the stack keeps its contents, and `stack_ovf` is 1 for exactly the next cycle.
- R10: A return executed while the stack is empty loads address 0, with the usual dead slot.
- R11: A word delivered in a dead slot has no effect, even if it encodes a call or return. `rom_addr` simply rises by 1 in the next cycle.
- R12: A reset in the middle of a run empties the stack, so the first return after it loads address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rom_addr | output | PC_W | Registered program counter, the address for the synchronous ROM |
| rom_data | input | PC_W+8 | ROM word for the address that was presented one cycle earlier |
| flag_zero | input | 1 | Zero flag from the datapath |
| flag_carry | input | 1 | Carry flag from the datapath |
| instr_out | output | PC_W+8 | Instruction to execute, zero in dead slots |
| exec_en | output | 1 | High when `instr_out` is to be executed this cycle |
| stack_ovf | output | 1 | One-cycle pulse after a call that found the stack full |

## Verification
Results fall due at three fixed offsets.
- **Same cycle:** `exec_en` and `instr_out` follow from the registered valid bit and the ROM word in the cycle the word is presented.
- **One cycle later:** the new `rom_addr` after any executed word, and `stack_ovf` after an overflowing call.
- **Two cycles later:** the target word of a taken branch is executed, after the dead slot.

The bench keeps a cycle model that advances on the rising edge from the same inputs the design sees. It compares all four outputs against that model on every falling edge. Each output is therefore judged in exactly the cycle its requirement names, and a result that arrives early or late fails.

// File: rtl/flow_pkg.sv
package flow_pkg;

  localparam int OPC_W = 8;

  // call opcodes share this 5-bit head; bit 2 of the opcode marks conditional
  localparam logic [4:0] CALL_HEAD = 5'b11000;
  localparam logic [7:0] RET_OPC   = 8'b10101100;

  typedef enum logic [1:0] {
    CC_ZERO    = 2'b00,
    CC_NZERO   = 2'b01,
    CC_CARRY   = 2'b10,
    CC_NCARRY  = 2'b11
  } cond_e;

  typedef struct packed {
    logic  is_call;
    logic  is_cond;
    cond_e cond;
    logic  is_ret;
  } dec_t;

endpackage

// File: rtl/flow_decode.sv
module flow_decode
  import flow_pkg::*;
#(
  parameter int PC_W = 10,
  localparam int IW  = OPC_W + PC_W
) (
  input  logic [IW-1:0]   instr,
  input  logic            valid,
  input  logic            zf,
  input  logic            cf,
  output logic            take_call,
  output logic            take_ret,
  output logic [PC_W-1:0] target
);

  logic [OPC_W-1:0] opc;
  dec_t             dec;
  logic             cond_ok;

  assign opc    = instr[IW-1:PC_W];
  assign target = instr[PC_W-1:0];

  always_comb begin
    dec.is_call = (opc[7:3] == CALL_HEAD) && (opc[2] || (opc[1:0] == 2'b00));
    dec.is_cond = opc[2];
    dec.cond    = cond_e'(opc[1:0]);
    dec.is_ret  = (opc == RET_OPC);
  end

  always_comb begin
    unique case (dec.cond)
      CC_ZERO:   cond_ok = zf;
      CC_NZERO:  cond_ok = !zf;
      CC_CARRY:  cond_ok = cf;
      CC_NCARRY: cond_ok = !cf;
      default:   cond_ok = 1'b0;
    endcase
  end

  assign take_call = valid && dec.is_call && (!dec.is_cond || cond_ok);
  assign take_ret  = valid && dec.is_ret;

endmodule

// File: rtl/flow_stack.sv
module flow_stack #(
  parameter int PC_W  = 10,
  parameter int DEPTH = 4,
  localparam int SP_W  = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push,
  input  logic            pop,
  input  logic [PC_W-1:0] push_data,
  output logic [PC_W-1:0] ret_addr,
  output logic            ovf
);

  logic [SP_W-1:0]  sp;
  logic             full;
  logic             empty;
  logic [IDX_W-1:0] wr_idx;
  logic [IDX_W-1:0] rd_idx;
  logic [PC_W-1:0]  mem [DEPTH];

  assign full   = (sp == SP_W'(DEPTH));
  assign empty  = (sp == '0);
  assign wr_idx = IDX_W'(sp);
  assign rd_idx = IDX_W'(sp - SP_W'(1));

  // storage has no reset so it maps to distributed RAM
  always_ff @(posedge clk) begin
    if (push && !full) begin
      mem[wr_idx] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp  <= '0;
      ovf <= 1'b0;
    end else begin
      ovf <= push && full;
      if (push && !full) begin
        sp <= sp + SP_W'(1);
      end else if (pop && !empty) begin
        sp <= sp - SP_W'(1);
      end
    end
  end

  assign ret_addr = empty ? '0 : mem[rd_idx];

endmodule

// File: rtl/flow_pc.sv
module flow_pc #(
  parameter int PC_W = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [PC_W-1:0] load_addr,
  output logic [PC_W-1:0] pc,
  output logic            valid
);

  // valid marks the ROM word arriving in the next cycle as executable
  always_ff @(posedge clk) begin
    if (rst) begin
      pc    <= '0;
      valid <= 1'b0;
    end else if (load) begin
      pc    <= load_addr;
      valid <= 1'b0;
    end else begin
      pc    <= pc + PC_W'(1);
      valid <= 1'b1;
    end
  end

endmodule

// File: rtl/mcu_flow_unit.sv
module mcu_flow_unit #(
  parameter int PC_W      = 10,
  parameter int STK_DEPTH = 4,
  localparam int IW       = flow_pkg::OPC_W + PC_W
) (
  input  logic            clk,
  input  logic            rst,
  output logic [PC_W-1:0] rom_addr,
  input  logic [IW-1:0]   rom_data,
  input  logic            flag_zero,
  input  logic            flag_carry,
  output logic [IW-1:0]   instr_out,
  output logic            exec_en,
  output logic            stack_ovf
);

  logic [PC_W-1:0] pc;
  logic            valid;
  logic            take_call;
  logic            take_ret;
  logic [PC_W-1:0] call_tgt;
  logic [PC_W-1:0] ret_tgt;
  logic            load;
  logic [PC_W-1:0] load_addr;

  flow_decode #(.PC_W(PC_W)) u_decode (
    .instr     (rom_data),
    .valid     (valid),
    .zf        (flag_zero),
    .cf        (flag_carry),
    .take_call (take_call),
    .take_ret  (take_ret),
    .target    (call_tgt)
  );

  // pc already holds the address after the executing word
  flow_stack #(.PC_W(PC_W), .DEPTH(STK_DEPTH)) u_stack (
    .clk       (clk),
    .rst       (rst),
    .push      (take_call),
    .pop       (take_ret),
    .push_data (pc),
    .ret_addr  (ret_tgt),
    .ovf       (stack_ovf)
  );

  assign load      = take_call || take_ret;
  assign load_addr = take_call ? call_tgt : ret_tgt;

  flow_pc #(.PC_W(PC_W)) u_pc (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_addr (load_addr),
    .pc        (pc),
    .valid     (valid)
  );

  assign rom_addr  = pc;
  assign exec_en   = valid;
  assign instr_out = valid ? rom_data : '0;

endmodule

// File: rtl/flow_chk.sv
module flow_chk #(
  parameter int PC_W = 10,
  localparam int IW  = PC_W + 8
) (
  input logic            clk,
  input logic            rst,
  input logic [PC_W-1:0] rom_addr,
  input logic [IW-1:0]   instr_out,
  input logic            exec_en,
  input logic            flag_zero,
  input logic            flag_carry,
  input logic            stack_ovf
);

  function automatic logic redirects(input logic [IW-1:0] w, input logic z, input logic c);
    logic [7:0] o;
    logic       hit;
    o = w[IW-1:PC_W];
    hit = 1'b0;
    if (o == 8'b11000000) hit = 1'b1;
    if (o == 8'b11000100) hit = z;
    if (o == 8'b11000101) hit = !z;
    if (o == 8'b11000110) hit = c;
    if (o == 8'b11000111) hit = !c;
    if (o == 8'b10101100) hit = 1'b1;
    return hit;
  endfunction

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (rom_addr == '0) && !exec_en);

  assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
    (exec_en && !redirects(instr_out, flag_zero, flag_carry))
      |=> (rom_addr == PC_W'($past(rom_addr) + 1)));

  assert_dead_slot_zero_R3: assert property (@(posedge clk) disable iff (rst)
    !exec_en |-> (instr_out == '0));

  assert_call_target_R4: assert property (@(posedge clk) disable iff (rst)
    (exec_en && (instr_out[IW-1:PC_W] == 8'b11000000))
      |=> (rom_addr == $past(instr_out[PC_W-1:0])) && !exec_en);

  assert_dead_no_effect_R11: assert property (@(posedge clk) disable iff (rst)
    !exec_en |=> (rom_addr == PC_W'($past(rom_addr) + 1)) && exec_en);

  assert_ovf_in_dead_slot_R9: assert property (@(posedge clk) disable iff (rst)
    stack_ovf |-> !exec_en);

endmodule

bind mcu_flow_unit flow_chk #(.PC_W(PC_W)) u_flow_chk (
  .clk        (clk),
  .rst        (rst),
  .rom_addr   (rom_addr),
  .instr_out  (instr_out),
  .exec_en    (exec_en),
  .flag_zero  (flag_zero),
  .flag_carry (flag_carry),
  .stack_ovf  (stack_ovf)
);

// File: tb/test_mcu_flow_unit.sv
`timescale 1ns/1ps
module test_mcu_flow_unit;

  localparam int PC_W  = 10;
  localparam int DEPTH = 4;
  localparam int IW    = PC_W + 8;
  localparam int ROM_N = 1 << PC_W;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [PC_W-1:0] rom_addr;
  logic [IW-1:0]   rom_q;
  logic            flag_zero = 1'b0;
  logic            flag_carry = 1'b0;
  logic [IW-1:0]   instr_out;
  logic            exec_en;
  logic            stack_ovf;

  logic [IW-1:0]   rom [ROM_N];

  int    checks = 0;
  int    fails  = 0;
  bit    started = 1'b0;
  bit    rand_flags = 1'b0;
  bit    done = 1'b0;
  string rst_tag = "R1";

  // model state
  logic [PC_W-1:0] m_pc;
  logic            m_valid;
  logic            m_ovf;
  logic [PC_W-1:0] m_stk [DEPTH];
  int              m_sp;
  int              m_since;
  string           m_tag;

  always #2.5 clk = ~clk;

  mcu_flow_unit #(.PC_W(PC_W), .STK_DEPTH(DEPTH)) i_mcu_flow_unit (
    .clk        (clk),
    .rst        (rst),
    .rom_addr   (rom_addr),
    .rom_data   (rom_q),
    .flag_zero  (flag_zero),
    .flag_carry (flag_carry),
    .instr_out  (instr_out),
    .exec_en    (exec_en),
    .stack_ovf  (stack_ovf)
  );

  always @(posedge clk) rom_q <= rom[rom_addr];
  always @(posedge clk) started <= 1'b1;

  function automatic logic [IW-1:0] mk(input logic [7:0] opc, input logic [PC_W-1:0] a);
    return {opc, a};
  endfunction

  function automatic logic cond_true(input logic [1:0] cc, input logic z, input logic c);
    case (cc)
      2'b00: return z;
      2'b01: return !z;
      2'b10: return c;
      default: return !c;
    endcase
  endfunction

  function automatic logic [IW-1:0] gen_word();
    int r;
    r = $urandom % 16;
    if (r < 2)  return mk(8'b11000000, PC_W'($urandom));
    if (r < 6)  return mk({6'b110001, 2'($urandom)}, PC_W'($urandom));
    if (r < 8)  return mk(8'b10101100, PC_W'($urandom));
    return {2'b00, 16'($urandom)};
  endfunction

  // cycle model built from the requirements
  always @(posedge clk) begin
    logic [7:0] o;
    if (rst) begin
      m_pc <= '0; m_valid <= 1'b0; m_ovf <= 1'b0; m_sp <= 0; m_since <= 0;
      m_tag <= rst_tag;
    end else begin
      m_since <= m_since + 1;
      m_ovf   <= 1'b0;
      o = rom_q[IW-1:PC_W];
      if (!m_valid) begin
        m_pc <= m_pc + 1'b1; m_valid <= 1'b1;
        m_tag <= (m_since == 0) ? rst_tag : "R11";
      end else if (o == 8'b11000000 ||
                   (o[7:2] == 6'b110001 && cond_true(o[1:0], flag_zero, flag_carry))) begin
        if (m_sp < DEPTH) begin
          m_stk[m_sp] <= m_pc; m_sp <= m_sp + 1;
          m_tag <= (o == 8'b11000000) ? "R4" : "R5";
        end else begin
          m_ovf <= 1'b1; m_tag <= "R9";
        end
        m_pc <= rom_q[PC_W-1:0]; m_valid <= 1'b0;
      end else if (o == 8'b10101100) begin
        if (m_sp > 0) begin
          m_pc <= m_stk[m_sp-1]; m_sp <= m_sp - 1;
          m_tag <= (m_sp > 1) ? "R8" : "R7";
        end else begin
          m_pc <= '0; m_tag <= "R10";
        end
        m_valid <= 1'b0;
      end else begin
        m_pc <= m_pc + 1'b1; m_valid <= 1'b1;
        m_tag <= (o[7:2] == 6'b110001) ? "R6" : "R2";
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (started && !done) begin
      chk(m_tag, 32'(rom_addr), 32'(m_pc), "rom_addr");
      chk(m_tag, 32'(exec_en), 32'(m_valid), "exec_en");
      chk("R3", 32'(instr_out), m_valid ? 32'(rom_q) : 32'd0, "instr_out");
      chk("R9", 32'(stack_ovf), 32'(m_ovf), "stack_ovf");
    end
    if (rand_flags) begin
      flag_zero  = 1'($urandom);
      flag_carry = 1'($urandom);
    end
  endtask

  task automatic clear_rom();
    for (int i = 0; i < ROM_N; i++) rom[i] = {2'b00, 16'(i)};
  endtask

  task automatic hold_reset(input string tag);
    rst_tag = tag;
    rst = 1'b1;
    repeat (2) step();
  endtask

  initial begin
    void'($urandom(32'd2024));
    clear_rom();
    // directed: calls, conditional calls and returns; z=0, c=1 held
    rom[1]      = mk(8'b11000000, 10'h100);
    rom[2]      = mk(8'b11000100, 10'h180);
    rom[3]      = mk(8'b11000101, 10'h180);
    rom[10'h100] = mk(8'b11000110, 10'h200);
    rom[10'h101] = mk(8'b10101100, 10'h000);
    rom[10'h200] = mk(8'b11000111, 10'h280);
    rom[10'h201] = mk(8'b10101100, 10'h000);
    rom[10'h180] = mk(8'b10101100, 10'h000);
    flag_zero = 1'b0; flag_carry = 1'b1;
    hold_reset("R1");
    rst = 1'b0;
    repeat (40) step();

    // nesting past the stack depth, then unwinding to an empty stack
    rst = 1'b1; clear_rom();
    rom[0] = mk(8'b11000000, 10'h080);
    for (int i = 0; i <= DEPTH + 1; i++) begin
      rom[10'h080 + 8*i]     = (i == DEPTH + 1) ? mk(8'b10101100, 10'h0)
                                                : mk(8'b11000000, PC_W'(10'h080 + 8*(i+1)));
      rom[10'h080 + 8*i + 1] = mk(8'b10101100, 10'h0);
    end
    hold_reset("R12");
    rst = 1'b0;
    repeat (60) step();

    // dead-slot call ignored; mid-run reset empties stack
    rst = 1'b1; clear_rom();
    rom[0]      = mk(8'b11000000, 10'h020);
    rom[1]      = mk(8'b11000000, 10'h030);
    rom[10'h020] = mk(8'b11000000, 10'h040);
    rom[10'h040] = mk(8'b10101100, 10'h0);
    rom[10'h041] = mk(8'b10101100, 10'h0);
    rom[10'h030] = mk(8'b10101100, 10'h0);
    hold_reset("R12");
    rst = 1'b0;
    repeat (9) step();
    hold_reset("R12");
    rom[0] = mk(8'b10101100, 10'h0);
    rst = 1'b0;
    repeat (20) step();

    // constrained random program with random flags
    rst = 1'b1;
    for (int i = 0; i < ROM_N; i++) rom[i] = gen_word();
    rand_flags = 1'b1;
    hold_reset("R1");
    rst = 1'b0;
    repeat (2500) step();
    hold_reset("R12");
    rst = 1'b0;
    repeat (2500) step();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule